// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse-Width Modulator

This block produces one pulse-width modulated output from a single system clock. Software controls it through four 16-bit registers on a small write/read port. The registers hold a run bit, a polarity bit, a 10-bit period, a 10-bit duty value and a power-of-two prescaler exponent. The counting rate is the system clock divided by two raised to the exponent. An internal counter steps from zero to period minus one at each prescaler tick. The output stays at its active level while the count is below the duty value.

The polarity bit selects the output levels. With polarity clear the pin rests high and is pulled low during the duty portion. With polarity set the pin rests low and is high during the duty portion.

The duty value may be rewritten while the output runs. The new value is taken up only when the next period starts, so no period is cut short or stretched. The period and the prescaler exponent are frozen while the run bit is set. Setting the run bit restarts the counter and the prescaler from zero, so the first period is always full length.

Top module: `pwm_core`

## Requirements
- R1: Byte offsets on `bus_addr` (bit 0 ignored) select the registers: 0 = control (bit 0 run, bit 1 polarity), 2 = period (bits 9:0), 4 = duty (bits 9:0), 6 = prescaler exponent (bits 4:0). `bus_rdata` returns the addressed register with every unused bit read as zero. After reset every register reads zero.
- R2: A written exponent above 11 is stored and read back as 11.
- R3: While the run bit is 1, writes to the period and exponent registers leave them unchanged.
- R4: The duty register accepts writes at any time, including while running, and reads back the new value at once.
- R5: While the run bit is 0, `pwm_out` equals the inverse of the polarity bit. This is 1 after reset.
- R6: While running with a nonzero period P, duty D and exponent S, the count holds each value for 2^S clocks and cycles 0..P-1. The output is active whenever count < D, so a duty of P or more gives a constant active level.
- R7: The active level of `pwm_out` equals the polarity bit.
- R8: A duty value written while running takes effect from the first clock of the next period.
- R9: A period of 0 keeps `pwm_out` at its idle level even while running.
- R10: The clock after the write that sets the run bit is the first clock of count 0, and every period starts that way after a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one register write per cycle |
| bus_addr | input | 3 | Byte offset of the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| pwm_out | output | 1 | Modulated output pin |

## Verification
The assertions assume that reset is held for at least one clock before any write. They also assume that `bus_addr`, `bus_wr` and `bus_wdata` change only away from the rising edge, so every write lands on exactly one edge. The bench meets these assumptions by holding reset for several cycles and driving every bus change on the falling edge. The bench also changes the period and exponent only while the block is stopped. It checks the locked-register behaviour by attempting writes that the design must refuse.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DATA_W    = 16;
    localparam int CNT_W     = 10;
    localparam int SHIFT_W   = 5;
    localparam int MAX_SHIFT = 11;
    localparam int SHQ_W     = $clog2(MAX_SHIFT + 1);
    localparam int DIV_W     = MAX_SHIFT;
    localparam int ADDR_W    = 3;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_SHIFT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              run;
        logic              invert;
        logic [CNT_W-1:0]  period;
        logic [CNT_W-1:0]  duty;
        logic [SHQ_W-1:0]  shift;
    } pwm_cfg_t;

    function automatic logic [SHQ_W-1:0] clamp_shift(input logic [SHIFT_W-1:0] raw);
        if (raw > SHIFT_W'(MAX_SHIFT))
            return SHQ_W'(MAX_SHIFT);
        return raw[SHQ_W-1:0];
    endfunction

    function automatic logic pin_level(input logic active, input logic invert);
        return active ? invert : ~invert;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output pwm_cfg_t          cfg
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr[ADDR_W-1:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL: begin
                    cfg.run    <= wdata[0];
                    cfg.invert <= wdata[1];
                end
                SEL_PERIOD: if (!cfg.run) cfg.period <= wdata[CNT_W-1:0];
                SEL_DUTY:   cfg.duty <= wdata[CNT_W-1:0];
                SEL_SHIFT:  if (!cfg.run) cfg.shift <= clamp_shift(wdata[SHIFT_W-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL:   rdata[1:0] = {cfg.invert, cfg.run};
            SEL_PERIOD: rdata[CNT_W-1:0] = cfg.period;
            SEL_DUTY:   rdata[CNT_W-1:0] = cfg.duty;
            SEL_SHIFT:  rdata[SHQ_W-1:0] = cfg.shift;
            default:    rdata = '0;
        endcase
    end

    a_r3_period_locked: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && wr && sel == SEL_PERIOD) |=> $stable(cfg.period));
    a_r3_shift_locked: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && wr && sel == SEL_SHIFT) |=> $stable(cfg.shift));
    a_r2_shift_range: assert property (@(posedge clk) disable iff (rst)
        cfg.shift <= SHQ_W'(MAX_SHIFT));
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SHQ_W-1:0] shift,
    output logic             tick
);
    logic [W-1:0] div_q;
    logic [W-1:0] mask;

    assign mask = (W'(1) << shift) - W'(1);
    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_q <= '0;
        else
            div_q <= div_q + W'(1);
    end

    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && shift != '0) |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         invert,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic         pwm_out
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] duty_act_q;
    logic         live;
    logic         last;
    logic         active;

    assign live   = period != '0;
    assign last   = live && (cnt_q == period - W'(1));
    assign active = run && live && (cnt_q < duty_act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            duty_act_q <= '0;
        end else if (!run) begin
            cnt_q      <= '0;
            duty_act_q <= duty;
        end else if (tick && live) begin
            if (last) begin
                cnt_q      <= '0;
                duty_act_q <= duty;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    assign pwm_out = pin_level(active, invert);

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        (run && live) |-> cnt_q < period);
    a_r8_duty_holds: assert property (@(posedge clk) disable iff (rst)
        (run && !(tick && last)) |=> $stable(duty_act_q));
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    pwm_cfg_t cfg;
    logic     tick;

    pwm_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    pwm_prescale #(.W(DIV_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (cfg.run),
        .shift (cfg.shift),
        .tick  (tick)
    );

    pwm_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.run),
        .tick    (tick),
        .invert  (cfg.invert),
        .period  (cfg.period),
        .duty    (cfg.duty),
        .pwm_out (pwm_out)
    );

    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        !cfg.run |-> pwm_out == !cfg.invert);
    a_r9_zero_period: assert property (@(posedge clk) disable iff (rst)
        (cfg.period == '0) |-> pwm_out == !cfg.invert);
endmodule

// File: tb/sim_pwm_core.sv
module sim_pwm_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pwm_out;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;

    pwm_core u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {polarity, shift[4:0], duty[9:0], period[9:0]}
    localparam int NV = 8;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 5'd0,  10'd1, 10'd4},
        {1'b1, 5'd1,  10'd3, 10'd5},
        {1'b0, 5'd0,  10'd0, 10'd10},
        {1'b1, 5'd0,  10'd6, 10'd6},
        {1'b0, 5'd2,  10'd9, 10'd7},
        {1'b1, 5'd3,  10'd2, 10'd3},
        {1'b0, 5'd0,  10'd2, 10'd0},
        {1'b0, 5'd11, 10'd1, 10'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic model(input int k, input int p, input int du,
                                   input int s, input logic pol);
        logic act;
        if (p == 0) act = 1'b0;
        else act = ((k >> s) % p) < du;
        return act ? pol : ~pol;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state: R1, R5
        for (int a = 0; a < 8; a += 2) begin
            rd(3'(a), rv);
            check(rv == 16'd0, "R1 reset readback", rv, 0);
        end
        check(pwm_out == 1'b1, "R5 reset idle high", pwm_out, 1);

        // reserved bits read zero: R1
        wr(3'd2, 16'hFFFF); rd(3'd2, rv);
        check(rv == 16'h03FF, "R1 period reserved bits", rv, 16'h03FF);
        wr(3'd0, 16'hFFFC); rd(3'd0, rv);
        check(rv == 16'h0000, "R1 control reserved bits", rv, 0);

        // exponent clamp: R2
        wr(3'd6, 16'd20); rd(3'd6, rv);
        check(rv == 16'd11, "R2 exponent clamp", rv, 11);
        wr(3'd6, 16'd5); rd(3'd6, rv);
        check(rv == 16'd5, "R2 exponent in range", rv, 5);

        // idle with polarity set: R5
        wr(3'd0, 16'h0002); #1;
        check(pwm_out == 1'b0, "R5 idle low with polarity", pwm_out, 0);

        // vector table: R6 R7 R9 R10
        foreach (VEC[i]) begin
            int p, du, s, len, bad;
            logic pol;
            p = int'(VEC[i][9:0]); du = int'(VEC[i][19:10]);
            s = int'(VEC[i][24:20]); pol = VEC[i][25];
            wr(3'd0, {14'd0, pol, 1'b0});
            wr(3'd2, 16'(p));
            wr(3'd4, 16'(du));
            wr(3'd6, 16'(s));
            #1;
            check(pwm_out == ~pol, "R5 idle before start", pwm_out, int'(~pol));
            bus_addr = 3'd0; bus_wdata = {14'd0, pol, 1'b1}; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
            len = ((p == 0) ? 1 : p) * (1 << s) * 2;
            bad = 0;
            for (int k = 0; k < len; k++) begin
                #1;
                if (pwm_out !== model(k, p, du, s, pol)) bad++;
                @(negedge clk);
            end
            check(bad == 0, $sformatf("R6 R7 R9 R10 vector %0d mismatching cycles", i), bad, 0);
        end

        // locked period and exponent, live duty: R3 R4 R8
        begin
            int bad;
            wr(3'd0, 16'h0000);
            wr(3'd2, 16'd8);
            wr(3'd4, 16'd2);
            wr(3'd6, 16'd0);
            wr(3'd0, 16'h0001);
            bad = 0;
            for (int k = 0; k < 3; k++) begin
                #1; if (pwm_out !== model(k, 8, 2, 0, 1'b0)) bad++;
                @(negedge clk);
            end
            #1; if (pwm_out !== model(3, 8, 2, 0, 1'b0)) bad++;
            wr(3'd4, 16'd6);          // commits entering k=4
            rd(3'd4, rv);
            check(rv == 16'd6, "R4 duty written while running", rv, 6);
            for (int k = 4; k < 16; k++) begin
                logic e;
                e = (k < 8) ? model(k, 8, 2, 0, 1'b0) : model(k, 8, 6, 0, 1'b0);
                if (k > 4) #1;
                if (pwm_out !== e) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R8 duty change deferred to next period", bad, 0);
            wr(3'd2, 16'd3); rd(3'd2, rv);
            check(rv == 16'd8, "R3 period write ignored while running", rv, 8);
            wr(3'd6, 16'd4); rd(3'd6, rv);
            check(rv == 16'd0, "R3 exponent write ignored while running", rv, 0);
            wr(3'd0, 16'h0000); #1;
            check(pwm_out == 1'b1, "R5 idle after stop", pwm_out, 1);
            wr(3'd2, 16'd3); rd(3'd2, rv);
            check(rv == 16'd3, "R3 period accepted when stopped", rv, 3);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule